// File: doc/BRIEF.md
# Pipelined Burst SRAM with Byte-Lane Writes

This block is a clocked single-port memory that acts like a no-wait-state synchronous SRAM. A command (read, write or deselect) is loaded together with an address on one rising edge. A write's data and byte-lane selects are taken on the following edge. A read's data is registered and appears after that following edge. While a write's data is being taken, the next command may already be loaded, so accesses can run back to back without idle cycles.

After a load, the `adv` input walks the same command through up to three more beats. Only the low two address bits change, in either linear or XOR-interleaved order. The order is picked by `order_il` and held from the load.

A sleep request is asynchronous. It passes through a synchronizer and a two-cycle transition into a sleep state. In that state commands are refused and stored words are kept. An access whose data edge falls after the synchronized request has arrived is dropped. Leaving sleep takes another two-cycle recovery, and commands seen during it are ignored.

The read/write bus is split into separate `din`, `dout` and `dout_oe` ports.

Control is built from two state machines:
- **Burst machine**:
  - States: `BST_IDLE`, `BST_READ`, `BST_WRITE`.
  - Transitions:
    - *load-read*, *load-write*: a load with `cs` high.
    - *deselect*: a load with `cs` low.
    - *advance*: `adv` high while a burst is running and fewer than four beats are done; the state stays.
    - *exhaust*: `adv` high on the fourth beat.
    - *abort*: access refused by the sleep logic.
- **Sleep machine**:
  - States: `SLP_AWAKE`, `SLP_ENTER`, `SLP_ASLEEP`, `SLP_EXIT`.
  - Transitions:
    - *request-seen*: AWAKE to ENTER when the synchronized request goes high.
    - *settled*: ENTER to ASLEEP after two cycles.
    - *release-seen*: ASLEEP to EXIT when the synchronized request goes low.
    - *re-request*: EXIT back to ASLEEP if the request returns.
    - *recovered*: EXIT to AWAKE after two cycles.

Top module: `burst_sram`

## Requirements
- R1: While `rst_n` is low and after reset, `dout_oe` is 0 and `dout` is 0 until the first read completes.
- R2: A command is taken on a rising edge with `adv`=0. With `cs`=1 and `we`=1 it writes, and the data on `din` is taken on the next rising edge. With `cs`=1 and `we`=0 it reads, and the word is on `dout` after the next rising edge.
- R3: Bit i of `be` (bits 8i+7..8i of the word) gates the write of lane i on each beat of a write, including every beat of a burst. Lanes whose bit is 0 keep their stored value.
- R4: With `adv`=1 a running burst moves to its next beat, and `cs` and `we` are ignored. At most four beats follow one load. An `adv` after the fourth beat, or with no burst running, performs no access.
- R5: With `order_il`=0 at the load, beat b (0..3) uses low bits (start + b) mod 4. Address bits above bit 1 stay those of the loaded address.
- R6: With `order_il`=1 at the load, beat b uses low bits start XOR b. The upper bits are fixed as in R5.
- R7: A new command may be loaded on the edge that takes the previous write's last data beat. A read loaded there returns the word just written.
- R8: `dout_oe` is 1 only in the cycle after a read's data edge, and only when `oe_in` is 1. It is 0 while a write's data phase is in progress, even if read data is present.
- R9: From two edges after `sleep_req` rises until the sleep machine has returned to AWAKE after release, every command is ignored and stored contents are kept. This includes a command presented on the edge right after `sleep_req` falls.
- R10: A write whose address edge precedes the synchronized sleep request, but whose data edge follows it, is dropped and leaves the stored word unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| addr | input | ADDR_W | Word address, taken on a load |
| cs | input | 1 | Chip select for a load (0 = deselect) |
| we | input | 1 | 1 = write, 0 = read, on a load |
| be | input | LANES | Byte-lane write selects, taken with write data |
| adv | input | 1 | 1 = advance the running burst, 0 = load a new command |
| order_il | input | 1 | Burst order on a load: 0 linear, 1 interleaved |
| sleep_req | input | 1 | Asynchronous sleep request |
| oe_in | input | 1 | Output enable request for read data |
| din | input | LANES*LANE_W | Write data |
| dout | output | LANES*LANE_W | Registered read data |
| dout_oe | output | 1 | Drive enable for `dout` |

## Verification
The bench fills the whole array, then walks all four start offsets in both burst orders and compares beat addresses arithmetically. A wrong order would read back rotated or swapped words. Every one of the sixteen lane masks is tried, and a mixed per-beat mask is tried in a burst; a design that latched the mask only at the load would corrupt lanes. The bench also covers:
- a read loaded on the last write beat, which a design with an extra data stage would return stale;
- a fifth advance, which a non-saturating counter would turn into a wrapped extra beat;
- a read followed directly by a write, where the output must go quiet;
- a write caught by the sleep request between its address and data edges, which a design without a drop path would commit.

// File: rtl/bsram_pkg.sv
package bsram_pkg;

    typedef enum logic [1:0] {
        BST_IDLE,
        BST_READ,
        BST_WRITE
    } burst_st_e;

    typedef enum logic [1:0] {
        SLP_AWAKE,
        SLP_ENTER,
        SLP_ASLEEP,
        SLP_EXIT
    } sleep_st_e;

    // Low two address bits for a given beat of a burst.
    function automatic logic [1:0] beat_lsb(input logic [1:0] start,
                                            input logic [1:0] beat,
                                            input logic       il);
        return il ? (start ^ beat) : (start + beat);
    endfunction

endpackage

// File: rtl/bsram_sleep_ctl.sv
module bsram_sleep_ctl
    import bsram_pkg::*;
#(
    parameter int SYNC_STAGES = 2,
    parameter int TRANS_CYC   = 2
) (
    input  logic      clk,
    input  logic      rst_n,
    input  logic      sleep_async,
    output sleep_st_e state,
    output logic      accept
);
    localparam int CW = $clog2(TRANS_CYC + 1);

    logic [SYNC_STAGES-1:0] sync_q;
    logic                   sleep_s;
    sleep_st_e              st_q, st_d;
    logic [CW-1:0]          cnt_q;
    logic                   cnt_done;

    // Synchronizer chain for the asynchronous request.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) sync_q <= '0;
        else        sync_q <= {sync_q[SYNC_STAGES-2:0], sleep_async};
    end
    assign sleep_s  = sync_q[SYNC_STAGES-1];
    assign cnt_done = (int'(cnt_q) == TRANS_CYC - 1);

    // State register and transition counter.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q  <= SLP_AWAKE;
            cnt_q <= '0;
        end else begin
            st_q <= st_d;
            if (st_d != st_q)                            cnt_q <= '0;
            else if (st_q == SLP_ENTER || st_q == SLP_EXIT) cnt_q <= cnt_q + 1'b1;
        end
    end

    // Next-state logic.
    always_comb begin
        st_d = st_q;
        unique case (st_q)
            SLP_AWAKE:  if (sleep_s)  st_d = SLP_ENTER;
            SLP_ENTER:  if (cnt_done) st_d = SLP_ASLEEP;
            SLP_ASLEEP: if (!sleep_s) st_d = SLP_EXIT;
            SLP_EXIT: begin
                if (sleep_s)       st_d = SLP_ASLEEP;
                else if (cnt_done) st_d = SLP_AWAKE;
            end
            default:    st_d = SLP_AWAKE;
        endcase
    end

    // Outputs.
    always_comb begin
        state  = st_q;
        accept = (st_q == SLP_AWAKE) && !sleep_s;
    end
endmodule

// File: rtl/bsram_burst_addr.sv
module bsram_burst_addr
    import bsram_pkg::*;
#(
    parameter int AW = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          load,
    input  logic          step,
    input  logic [AW-1:0] addr_in,
    input  logic          il_in,
    output logic [AW-1:0] acc_addr,
    output logic          last_beat,
    output logic          il_q
);
    logic [AW-1:0] base_q;
    logic [1:0]    beat_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            base_q <= '0;
            beat_q <= '0;
            il_q   <= 1'b0;
        end else if (load) begin
            base_q <= addr_in;
            beat_q <= '0;
            il_q   <= il_in;
        end else if (step) begin
            beat_q <= beat_q + 2'd1;
        end
    end

    always_comb begin
        if (load) acc_addr = addr_in;
        else      acc_addr = {base_q[AW-1:2], beat_lsb(base_q[1:0], beat_q + 2'd1, il_q)};
        last_beat = (beat_q == 2'd3);
    end
endmodule

// File: rtl/bsram_array.sv
module bsram_array #(
    parameter int AW     = 8,
    parameter int LANES  = 4,
    parameter int LANE_W = 8
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    wr_en,
    input  logic [LANES-1:0]        wr_be,
    input  logic [AW-1:0]           wr_addr,
    input  logic [LANES*LANE_W-1:0] wr_data,
    input  logic                    rd_en,
    input  logic [AW-1:0]           rd_addr,
    output logic [LANES*LANE_W-1:0] rd_data
);
    localparam int DEPTH = 1 << AW;

    for (genvar g = 0; g < LANES; g++) begin : g_lane
        logic [LANE_W-1:0] mem [DEPTH];
        logic [LANE_W-1:0] rd_q;

        always_ff @(posedge clk) begin
            if (wr_en && wr_be[g]) mem[wr_addr] <= wr_data[g*LANE_W +: LANE_W];
        end

        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)     rd_q <= '0;
            else if (rd_en) rd_q <= mem[rd_addr];
        end

        assign rd_data[g*LANE_W +: LANE_W] = rd_q;
    end
endmodule

// File: rtl/burst_sram.sv
module burst_sram
    import bsram_pkg::*;
#(
    parameter int ADDR_W     = 8,
    parameter int LANES      = 4,
    parameter int LANE_W     = 8,
    parameter int SLEEP_SYNC = 2,
    parameter int SLEEP_CYC  = 2
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic [ADDR_W-1:0]       addr,
    input  logic                    cs,
    input  logic                    we,
    input  logic [LANES-1:0]        be,
    input  logic                    adv,
    input  logic                    order_il,
    input  logic                    sleep_req,
    input  logic                    oe_in,
    input  logic [LANES*LANE_W-1:0] din,
    output logic [LANES*LANE_W-1:0] dout,
    output logic                    dout_oe
);
    localparam int DATA_W = LANES * LANE_W;

    sleep_st_e          sleep_st;
    logic               accept;
    burst_st_e          burst_st_q, burst_st_d;
    logic               load, start, cont;
    logic [ADDR_W-1:0]  acc_addr;
    logic               last_beat;
    logic               il_q;
    logic               a_valid, a_write;
    logic [ADDR_W-1:0]  a_addr;
    logic               mem_we, mem_re;
    logic               rd_q;
    logic [DATA_W-1:0]  rd_data;

    bsram_sleep_ctl #(
        .SYNC_STAGES (SLEEP_SYNC),
        .TRANS_CYC   (SLEEP_CYC)
    ) u_sleep (
        .clk         (clk),
        .rst_n       (rst_n),
        .sleep_async (sleep_req),
        .state       (sleep_st),
        .accept      (accept)
    );

    assign load  = accept && !adv;
    assign start = load && cs;
    assign cont  = accept && adv && (burst_st_q != BST_IDLE) && !last_beat;

    bsram_burst_addr #(.AW(ADDR_W)) u_addr (
        .clk       (clk),
        .rst_n     (rst_n),
        .load      (load),
        .step      (cont),
        .addr_in   (addr),
        .il_in     (order_il),
        .acc_addr  (acc_addr),
        .last_beat (last_beat),
        .il_q      (il_q)
    );

    // Burst state register.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) burst_st_q <= BST_IDLE;
        else        burst_st_q <= burst_st_d;
    end

    // Burst next-state logic.
    always_comb begin
        burst_st_d = burst_st_q;
        unique case (burst_st_q)
            BST_IDLE: begin
                if (load && cs) burst_st_d = we ? BST_WRITE : BST_READ;
            end
            BST_READ, BST_WRITE: begin
                if (!accept)                burst_st_d = BST_IDLE;
                else if (!adv)              burst_st_d = !cs ? BST_IDLE : (we ? BST_WRITE : BST_READ);
                else if (last_beat)         burst_st_d = BST_IDLE;
            end
            default: burst_st_d = BST_IDLE;
        endcase
    end

    // Address-phase register: the access whose data edge is next.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            a_valid <= 1'b0;
            a_write <= 1'b0;
            a_addr  <= '0;
            rd_q    <= 1'b0;
        end else begin
            a_valid <= start || cont;
            a_write <= start ? we : (burst_st_q == BST_WRITE);
            a_addr  <= acc_addr;
            rd_q    <= mem_re;
        end
    end

    assign mem_we = a_valid && a_write && accept;
    assign mem_re = a_valid && !a_write && accept;

    bsram_array #(
        .AW     (ADDR_W),
        .LANES  (LANES),
        .LANE_W (LANE_W)
    ) u_array (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (mem_we),
        .wr_be   (be),
        .wr_addr (a_addr),
        .wr_data (din),
        .rd_en   (mem_re),
        .rd_addr (a_addr),
        .rd_data (rd_data)
    );

    // Outputs.
    always_comb begin
        dout    = rd_data;
        dout_oe = rd_q && oe_in && !(a_valid && a_write);
    end
endmodule

// File: rtl/burst_sram_chk.sv
module burst_sram_chk
    import bsram_pkg::*;
#(
    parameter int AW = 8
) (
    input logic          clk,
    input logic          rst_n,
    input logic          adv,
    input logic          accept,
    input burst_st_e     burst_st_q,
    input logic          last_beat,
    input logic          il_q,
    input logic          a_valid,
    input logic          a_write,
    input logic [AW-1:0] a_addr,
    input logic          dout_oe,
    input sleep_st_e     sleep_st
);
    // R5/R6: upper address bits stay fixed along a burst
    assert_upper_fixed_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (burst_st_q != BST_IDLE && adv && accept && !last_beat)
        |=> (a_valid && a_addr[AW-1:2] == $past(a_addr[AW-1:2])));

    // R5: linear order steps the low bits by one
    assert_linear_step_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (burst_st_q != BST_IDLE && adv && accept && !last_beat && !il_q)
        |=> (a_addr[1:0] == $past(a_addr[1:0]) + 2'd1));

    // R6: interleaved order never repeats a beat address
    assert_il_moves_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (burst_st_q != BST_IDLE && adv && accept && !last_beat && il_q)
        |=> (a_addr[1:0] != $past(a_addr[1:0])));

    // R4: an advance on the fourth beat ends the burst
    assert_four_beats_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (burst_st_q != BST_IDLE && adv && last_beat) |=> (burst_st_q == BST_IDLE && !a_valid));

    // R8: output drive only after an accepted read data edge
    assert_oe_after_read_R8: assert property (@(posedge clk) disable iff (!rst_n)
        dout_oe |-> $past(a_valid && !a_write && accept));

    // R9: no access is registered while not awake
    assert_sleep_blocks_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (sleep_st != SLP_AWAKE) |=> !a_valid);
endmodule

bind burst_sram burst_sram_chk #(.AW(ADDR_W)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .adv        (adv),
    .accept     (accept),
    .burst_st_q (burst_st_q),
    .last_beat  (last_beat),
    .il_q       (il_q),
    .a_valid    (a_valid),
    .a_write    (a_write),
    .a_addr     (a_addr),
    .dout_oe    (dout_oe),
    .sleep_st   (sleep_st)
);

// File: tb/burst_sram_test.sv
module burst_sram_test;
    localparam int AW = 8;
    localparam int DEPTH = 1 << AW;

    logic          clk = 1'b0;
    logic          rst_n;
    logic [AW-1:0] addr;
    logic          cs, we, adv, order_il, sleep_req, oe_in;
    logic [3:0]    be;
    logic [31:0]   din, dout;
    logic          dout_oe;

    logic [31:0] model [DEPTH];
    int checks = 0;
    int errors = 0;

    always #2 clk = ~clk;

    burst_sram uut (
        .clk(clk), .rst_n(rst_n), .addr(addr), .cs(cs), .we(we), .be(be),
        .adv(adv), .order_il(order_il), .sleep_req(sleep_req), .oe_in(oe_in),
        .din(din), .dout(dout), .dout_oe(dout_oe)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic tick();
        @(negedge clk);
    endtask

    task automatic set_idle();
        cs = 0; we = 0; adv = 0; be = 4'h0; din = '0; addr = '0;
    endtask

    function automatic logic [1:0] lsb(input logic [1:0] s, input int b, input logic il);
        return il ? (s ^ 2'(b)) : 2'((int'(s) + b) % 4);
    endfunction

    function automatic logic [AW-1:0] baddr(input logic [AW-1:0] a, input int b, input logic il);
        return {a[AW-1:2], lsb(a[1:0], b, il)};
    endfunction

    function automatic logic [31:0] merge(input logic [31:0] o, input logic [31:0] n, input logic [3:0] m);
        logic [31:0] r = o;
        for (int i = 0; i < 4; i++) if (m[i]) r[8*i +: 8] = n[8*i +: 8];
        return r;
    endfunction

    function automatic logic [31:0] beat_data(input logic [31:0] d0, input int b);
        return d0 ^ (32'(b) * 32'h11111111);
    endfunction

    // Load a write, feed n data beats, return with idle inputs applied.
    task automatic wr_burst(input logic [AW-1:0] a, input int n, input logic il,
                            input logic [31:0] d0, input logic [15:0] be_all);
        for (int b = 0; b < n; b++) begin
            if (b == 0) begin
                adv = 0; cs = 1; we = 1; addr = a; order_il = il;
            end else begin
                adv = 1; cs = 0; we = 0; addr = ~a;   // cs/we ignored (R4)
                din = beat_data(d0, b - 1); be = be_all[4*(b-1) +: 4];
            end
            tick();
        end
        set_idle();
        din = beat_data(d0, n - 1); be = be_all[4*(n-1) +: 4];
        tick();
        for (int b = 0; b < n; b++)
            model[baddr(a, b, il)] = merge(model[baddr(a, b, il)], beat_data(d0, b), be_all[4*b +: 4]);
        set_idle();
    endtask

    task automatic rd_burst(input logic [AW-1:0] a, input int n, input logic il, input string req);
        for (int b = 0; b < n; b++) begin
            if (b == 0) begin
                adv = 0; cs = 1; we = 0; addr = a; order_il = il;
            end else begin
                adv = 1; cs = 0; we = 1;                 // ignored during advance (R4)
            end
            tick();
            if (b > 0) begin
                chk(req, dout, model[baddr(a, b - 1, il)]);
                chk("R8 oe on read", {31'b0, dout_oe}, 32'd1);
            end
        end
        set_idle();
        tick();
        chk(req, dout, model[baddr(a, n - 1, il)]);
        chk("R8 oe on read", {31'b0, dout_oe}, 32'd1);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        rst_n = 0; set_idle(); order_il = 0; sleep_req = 0; oe_in = 1;
        repeat (3) tick();
        chk("R1 reset oe", {31'b0, dout_oe}, 32'd0);
        chk("R1 reset dout", dout, 32'd0);
        rst_n = 1;
        tick();
        chk("R1 after reset oe", {31'b0, dout_oe}, 32'd0);

        // R2: fill every word with single writes, read back as linear bursts (R5)
        for (int a = 0; a < DEPTH; a++) begin
            model[a] = 'x;
            wr_burst(AW'(a), 1, 1'b0, {8'(a), ~8'(a), 8'(a) ^ 8'h5A, 8'hC3}, 16'h000F);
        end
        for (int g = 0; g < DEPTH / 4; g++) rd_burst(AW'(g * 4), 4, 1'b0, "R2/R5 fill readback");

        // R5/R6: all start offsets in both orders
        for (int il = 0; il < 2; il++) begin
            for (int s = 0; s < 4; s++) begin
                wr_burst(AW'(8'h40 + s), 4, il[0], 32'hA0000000 + 32'(s * 256 + il), 16'hFFFF);
                for (int k = 0; k < 4; k++)
                    rd_burst(AW'(8'h40 + k), 1, 1'b0, il ? "R6 interleaved map" : "R5 linear map");
                rd_burst(AW'(8'h44 + s), 4, il[0], il ? "R6 interleaved read" : "R5 linear read");
            end
        end

        // R3: every lane mask on a single write
        for (int m = 0; m < 16; m++) begin
            wr_burst(8'h80, 1, 1'b0, 32'hFFFFFFFF, 16'h000F);
            wr_burst(8'h80, 1, 1'b0, 32'h12345678 + 32'(m), {12'h000, 4'(m)});
            rd_burst(8'h80, 1, 1'b0, "R3 lane mask");
        end
        // R3: different mask on each beat of a burst
        wr_burst(8'h84, 4, 1'b0, 32'h00000000, 16'hFFFF);
        wr_burst(8'h86, 4, 1'b1, 32'hCAFEF00D, 16'h8421);
        for (int k = 0; k < 4; k++) rd_burst(AW'(8'h84 + k), 1, 1'b0, "R3 per-beat mask");

        // R7: read loaded on the edge taking the last write beat
        adv = 0; cs = 1; we = 1; addr = 8'h93; order_il = 0; tick();
        for (int b = 1; b < 4; b++) begin
            adv = 1; cs = 0; din = beat_data(32'h5EED0000, b - 1); be = 4'hF; tick();
        end
        adv = 0; cs = 1; we = 0; addr = 8'h92; din = beat_data(32'h5EED0000, 3); be = 4'hF;
        tick();
        for (int b = 0; b < 4; b++) model[baddr(8'h93, b, 1'b0)] = beat_data(32'h5EED0000, b);
        set_idle(); tick();
        chk("R7 read after burst write", dout, model[8'h92]);

        // R8: oe_in low keeps the output off; data still registered
        oe_in = 0;
        adv = 0; cs = 1; we = 0; addr = 8'h10; tick();
        set_idle(); tick();
        chk("R8 oe_in low", {31'b0, dout_oe}, 32'd0);
        chk("R8 data with oe_in low", dout, model[8'h10]);
        oe_in = 1;
        // R8: write right after a read forces the output off
        adv = 0; cs = 1; we = 0; addr = 8'h11; tick();
        adv = 0; cs = 1; we = 1; addr = 8'h12; tick();
        chk("R8 forced off in write data phase", {31'b0, dout_oe}, 32'd0);
        chk("R8 read data present", dout, model[8'h11]);
        set_idle(); din = 32'h0BADCAFE; be = 4'hF; tick();
        model[8'h12] = 32'h0BADCAFE;
        set_idle();
        rd_burst(8'h12, 1, 1'b0, "R8 write after read");

        // R4: fifth advance makes no access
        adv = 0; cs = 1; we = 0; addr = 8'h20; order_il = 0; tick();
        for (int b = 1; b < 6; b++) begin
            adv = 1; cs = 1; we = 0; tick();
            if (b == 5) chk("R4 fourth beat data", dout, model[8'h23]);
        end
        set_idle(); tick();
        chk("R4 no fifth beat", {31'b0, dout_oe}, 32'd0);
        // R4: advance with no burst running
        adv = 1; tick(); tick();
        chk("R4 advance from idle", {31'b0, dout_oe}, 32'd0);
        set_idle(); tick();

        // R9: commands during sleep and early recovery are ignored
        sleep_req = 1;
        repeat (8) tick();
        adv = 0; cs = 1; we = 1; addr = 8'hA0; tick();
        set_idle(); din = 32'hDEADBEEF; be = 4'hF; tick();
        adv = 0; cs = 1; we = 0; addr = 8'hA0; tick();
        set_idle(); tick();
        chk("R9 no read in sleep", {31'b0, dout_oe}, 32'd0);
        sleep_req = 0;
        adv = 0; cs = 1; we = 1; addr = 8'hA1; tick();
        set_idle(); din = 32'h77777777; be = 4'hF; tick();
        repeat (8) tick();
        rd_burst(8'hA0, 1, 1'b0, "R9 contents kept through sleep");
        rd_burst(8'hA1, 1, 1'b0, "R9 recovery command ignored");

        // R10: write in flight when sleep arrives is dropped
        sleep_req = 1; tick();
        adv = 0; cs = 1; we = 1; addr = 8'hB0; tick();
        set_idle(); din = 32'h13579BDF; be = 4'hF; tick();
        repeat (6) tick();
        sleep_req = 0;
        repeat (10) tick();
        rd_burst(8'hB0, 1, 1'b0, "R10 in-flight write dropped");

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule